// File: doc/BRIEF.md
# Timed Power-Off Wake Supervisor

This block lets a node cut its own supply for a programmed interval and bring it back without outside help. It owns the enable line of the main voltage regulator and decides, through a small state machine, whether that line follows the host or is driven by the supervisor. It runs on an always-on low-rate clock domain. A `tick` strobe, one pulse per second of off-time, paces the off-time counter.

The host uses a two-entry write-only register port, which stands in for a serial two-wire bus. Address 0 holds the off-duration in ticks. Address 1 takes commands: bit 0 arms, bit 1 clears the wake interrupt and bit 2 clears the arm-error flag.

An accepted arm does three things: it drops the regulator enable, loads the counter from the stored duration and counts down on `tick`. When the count runs out, the supervisor raises the enable again and sets a sticky wake interrupt. It keeps the enable high until the host asserts its own enable, and then hands control back.

Top module: `wake_supervisor`

## Requirements
- R1: After reset the host owns the enable (`host_owns`=1), `off_active`=0, `wake_irq`=0 and `arm_err`=0.
- R2: While the host owns it, `reg_en` equals `host_en` in the same cycle.
- R3: An arm command (write to address 1 with bit 0 set) is accepted only when the host owns the enable, `stby_sel`=1 and the stored duration is nonzero. From the next cycle `off_active`=1, `host_owns`=0 and `reg_en`=0.
- R4: An arm in the host-owned state with `stby_sel`=0 or a zero duration leaves the state unchanged and sets `arm_err` from the next cycle. The flag stays set until a write to address 1 with bit 2 set, and setting wins over clearing.
- R5: With a stored duration of N ticks, the block stays off through exactly N `tick` pulses. In the cycle after the N-th pulse it leaves the off state with `reg_en`=1 and `wake_irq`=1.
- R6: While off, `reg_en` stays 0 whatever `host_en` does, and register writes of any kind are dropped.
- R7: After wake-up the supervisor holds `reg_en`=1 while `host_en`=0. The cycle after `host_en`=1 is seen, the host owns the enable again.
- R8: `wake_irq` stays 1 until a write to address 1 with bit 1 set, made outside the off state.
- R9: The counter is loaded only by an accepted arm. A second shutdown with no new duration write lasts the same number of ticks.
- R10: `tick` pulses outside the off state do not change the length of the next shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe per off-time unit |
| stby_sel | input | 1 | Standby selector switch, 1 = standby position |
| host_en | input | 1 | Enable level requested by the host |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = duration, 1 = command |
| reg_wdata | input | DUR_W | Write data |
| reg_en | output | 1 | Regulator enable |
| host_owns | output | 1 | Host currently controls the enable |
| off_active | output | 1 | Timed shutdown in progress |
| wake_irq | output | 1 | Sticky wake interrupt to the host |
| arm_err | output | 1 | Sticky rejected-arm flag |

## Verification
Some properties are checked on every cycle. The counter is never zero while running, and a rejected arm always raises the error flag. Both the off state and the post-wake hold last as long as their exit condition is absent. A rising interrupt always follows a counter expiry. Only the bench scenarios can show the rest: the exact tick count of a shutdown, that writes made while off are lost, that a second shutdown reuses the stored duration, and that stray ticks in the host-owned state have no lasting effect.

// File: rtl/wake_sup_pkg.sv
package wake_sup_pkg;
    typedef enum logic [1:0] {
        PS_HOST = 2'd0,
        PS_OFF  = 2'd1,
        PS_WAKE = 2'd2
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e state;
        logic       irq;
        logic       err;
    } ctrl_regs_t;

    localparam int CMD_ARM_BIT  = 0;
    localparam int CMD_CIRQ_BIT = 1;
    localparam int CMD_CERR_BIT = 2;
endpackage

// File: rtl/wake_cfg_regs.sv
module wake_cfg_regs #(
    parameter int DUR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             addr,
    input  logic [DUR_W-1:0] wdata,
    input  logic             accept,
    output logic [DUR_W-1:0] dur_q,
    output logic             arm_req,
    output logic             clr_irq,
    output logic             clr_err
);
    import wake_sup_pkg::*;

    logic [DUR_W-1:0] dur_d;
    logic             cmd_wr;

    always_comb begin
        cmd_wr  = wr && accept && addr;
        arm_req = cmd_wr && wdata[CMD_ARM_BIT];
        clr_irq = cmd_wr && wdata[CMD_CIRQ_BIT];
        clr_err = cmd_wr && wdata[CMD_CERR_BIT];
        dur_d   = dur_q;
        if (wr && accept && !addr) begin
            dur_d = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dur_q <= '0;
        end else begin
            dur_q <= dur_d;
        end
    end
endmodule

// File: rtl/wake_off_timer.sv
module wake_off_timer #(
    parameter int DUR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DUR_W-1:0] load_val,
    input  logic             run,
    input  logic             tick,
    output logic             expire
);
    localparam logic [DUR_W-1:0] ONE = DUR_W'(1);

    logic [DUR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = run && tick && (cnt_q == ONE);
        if (load) begin
            cnt_d = load_val;
        end else if (run && tick && !expire) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R5
    cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q != '0);

    // R3
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> load_val != '0);
endmodule

// File: rtl/wake_ctrl_fsm.sv
module wake_ctrl_fsm (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      arm_req,
    input  logic                      dur_zero,
    input  logic                      stby_sel,
    input  logic                      host_en,
    input  logic                      expire,
    input  logic                      clr_irq,
    input  logic                      clr_err,
    output wake_sup_pkg::pwr_state_e  state,
    output logic                      load,
    output logic                      irq,
    output logic                      err
);
    import wake_sup_pkg::*;

    ctrl_regs_t r_d, r_q;
    logic       arm_bad;

    always_comb begin
        r_d     = r_q;
        arm_bad = 1'b0;
        load    = 1'b0;
        if (clr_irq) r_d.irq = 1'b0;
        if (clr_err) r_d.err = 1'b0;
        unique case (r_q.state)
            PS_HOST: begin
                if (arm_req) begin
                    if (stby_sel && !dur_zero) begin
                        load      = 1'b1;
                        r_d.state = PS_OFF;
                    end else begin
                        arm_bad = 1'b1;
                    end
                end
            end
            PS_OFF: begin
                if (expire) begin
                    r_d.state = PS_WAKE;
                    r_d.irq   = 1'b1;
                end
            end
            PS_WAKE: begin
                if (host_en) r_d.state = PS_HOST;
            end
            default: r_d.state = PS_HOST;
        endcase
        if (arm_bad) r_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: PS_HOST, irq: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.state;
    assign irq   = r_q.irq;
    assign err   = r_q.err;

    // R4
    arm_bad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_HOST && arm_req && (!stby_sel || dur_zero)) |=> err);

    // R5
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_OFF && !expire) |=> r_q.state == PS_OFF);

    // R7
    wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == PS_WAKE && !host_en) |=> r_q.state == PS_WAKE);

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(expire));
endmodule

// File: rtl/wake_supervisor.sv
module wake_supervisor #(
    parameter int DUR_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             stby_sel,
    input  logic             host_en,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [DUR_W-1:0] reg_wdata,
    output logic             reg_en,
    output logic             host_owns,
    output logic             off_active,
    output logic             wake_irq,
    output logic             arm_err
);
    import wake_sup_pkg::*;

    pwr_state_e       state;
    logic [DUR_W-1:0] dur;
    logic             arm_req, clr_irq, clr_err, load, expire;

    wake_cfg_regs #(.DUR_W(DUR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .accept(state != PS_OFF), .dur_q(dur),
        .arm_req(arm_req), .clr_irq(clr_irq), .clr_err(clr_err)
    );

    wake_off_timer #(.DUR_W(DUR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(dur),
        .run(state == PS_OFF), .tick(tick), .expire(expire)
    );

    wake_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .dur_zero(dur == '0),
        .stby_sel(stby_sel), .host_en(host_en), .expire(expire),
        .clr_irq(clr_irq), .clr_err(clr_err), .state(state),
        .load(load), .irq(wake_irq), .err(arm_err)
    );

    assign host_owns  = (state == PS_HOST);
    assign off_active = (state == PS_OFF);
    assign reg_en     = host_owns ? host_en : (state == PS_WAKE);

    // R6
    off_en_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off_active && $past(off_active)) |-> $stable(reg_en));
endmodule

// File: tb/wake_supervisor_tb.sv
module wake_supervisor_tb;
    localparam int DUR_W = 24;

    logic clk = 0, rst_n = 0, tick = 0, stby_sel = 0, host_en = 0;
    logic reg_wr = 0, reg_addr = 0;
    logic [DUR_W-1:0] reg_wdata = '0;
    logic reg_en, host_owns, off_active, wake_irq, arm_err;

    int checks = 0, fails = 0, cycles = 0;
    bit cmp_on = 0;

    // behavioural reference: 0 host, 1 off, 2 wake
    int m_st = 0, m_cnt = 0, m_dur = 0;
    bit m_irq = 0, m_err = 0;

    always #5 clk = ~clk;

    wake_supervisor #(.DUR_W(DUR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .stby_sel(stby_sel),
        .host_en(host_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_en(reg_en), .host_owns(host_owns),
        .off_active(off_active), .wake_irq(wake_irq), .arm_err(arm_err)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_dur = 0; m_irq = 0; m_err = 0;
        end else begin
            bit cmd, set_irq, set_err;
            cmd = reg_wr && reg_addr && m_st != 1;
            set_irq = 0; set_err = 0;
            case (m_st)
                0: begin
                    if (reg_wr && !reg_addr) m_dur = int'(reg_wdata);
                    else if (cmd && reg_wdata[0]) begin
                        if (stby_sel && m_dur != 0) begin m_st = 1; m_cnt = m_dur; end
                        else set_err = 1;
                    end
                end
                1: if (tick) begin
                    if (m_cnt == 1) begin m_st = 2; set_irq = 1; end
                    else m_cnt--;
                end
                default: begin
                    if (reg_wr && !reg_addr) m_dur = int'(reg_wdata);
                    if (host_en) m_st = 0;
                end
            endcase
            if (cmd && reg_wdata[1]) m_irq = 0;
            if (cmd && reg_wdata[2]) m_err = 0;
            if (set_irq) m_irq = 1;
            if (set_err) m_err = 1;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(m_st == 0 ? "R2" : (m_st == 1 ? "R6" : "R7"),
                reg_en, m_st == 0 ? host_en : (m_st == 2));
            chk("R3", host_owns, m_st == 0);
            chk("R5", off_active, m_st == 1);
            chk("R8", wake_irq, m_irq);
            chk("R4", arm_err, m_err);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic cyc(); @(posedge clk); #2; endtask

    task automatic wr(bit a, int d);
        reg_wr = 1; reg_addr = a; reg_wdata = DUR_W'(d); cyc();
        reg_wr = 0; reg_addr = 0; reg_wdata = '0;
    endtask

    // count tick pulses until the shutdown ends
    task automatic run_off(string tag, int exp_ticks);
        int n = 0;
        while (off_active && n < 50) begin
            tick = 1; cyc(); tick = 0; n++;
            host_en = ~host_en; cyc();
        end
        host_en = 0;
        chk(tag, n, exp_ticks);
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1; cmp_on = 1;
        #1;
        // R1 reset state
        chk("R1", host_owns, 1); chk("R1", off_active, 0);
        chk("R1", wake_irq, 0);  chk("R1", arm_err, 0);
        host_en = 1; cyc(); host_en = 0; cyc(); host_en = 1; cyc();
        // R4: zero duration and no standby
        wr(1, 1); cyc(); chk("R4", arm_err, 1);
        wr(1, 4); chk("R4", arm_err, 0);
        // R4: nonzero duration but standby off
        wr(0, 3); wr(1, 1); chk("R4", off_active, 0); wr(1, 4);
        // R3/R5: accepted arm, R10 ticks before have no effect
        tick = 1; cyc(); tick = 0; cyc();
        stby_sel = 1; wr(1, 1);
        chk("R3", reg_en, 0);
        wr(0, 9); wr(1, 1); // R6 dropped while off
        run_off("R5", 3);
        // R7 hold while host_en low
        repeat (3) cyc(); chk("R7", reg_en, 1);
        host_en = 1; cyc(); chk("R7", host_owns, 1);
        chk("R8", wake_irq, 1);
        wr(1, 2); chk("R8", wake_irq, 0);
        // R9 / R10: second shutdown without rewrite, stray ticks first
        repeat (2) begin tick = 1; cyc(); tick = 0; cyc(); end
        wr(1, 1);
        run_off("R9", 3);
        host_en = 1; cyc(); wr(1, 2);
        // single-tick duration and err/irq set priority on the same write
        wr(0, 1); wr(1, 1); run_off("R10", 1);
        host_en = 1; cyc();
        stby_sel = 0; wr(1, 7); chk("R4", arm_err, 1); chk("R8", wake_irq, 0);
        wr(1, 4); repeat (2) cyc();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule